// File: doc/BRIEF.md
# Microstepping Excitation Phase Sequencer

This block is the digital heart of a two-winding stepper motor controller. It keeps an electrical angle as a 6-bit position, with 64 positions in one full electrical turn. Each accepted step moves the position by an amount set by the selected excitation mode. The modes run from a coarse full-step drive, where both windings are always energised, to a fine sixteenth-step drive. From the position it derives a current-ratio code for each winding and a forward/reverse drive pair per winding. It also flags when the angle sits at its 45-degree home point.

A system integrator supplies a clean, already-synchronised step level, a direction bit, an edge-rule select and a two-bit mode field. The edge-rule select decides whether only rising step edges count or both edges do, and it also shifts the mode ladder one notch finer. The ratio codes feed an external reference DAC and chopper. The drive pair selects winding polarity.

When the mode changes, the position is kept. On the next step the sequencer lands on the nearest valid point of the new mode, moving in the direction of travel. Pulling enable low freezes the angle and switches every drive off.

Top module: `ustep_sequencer`

## Requirements
- R1: While rst_n is low, and after its release until the first accepted step, the position is the home point 8. With enable high, both a_level and b_level read code 9 (71%), at_origin is 1, and a_fwd and b_fwd are on while a_rev and b_rev are off.
- R2: The step size in positions comes from single_edge and mode_sel. With single_edge=1, mode_sel 0,1,2,3 give 16, 8, 4 and 2. With single_edge=0, the same codes give 8, 4, 2 and 1.
- R3: dir_ccw=0 moves the position upward (modulo 64) on each accepted step. dir_ccw=1 moves it downward.
- R4: With single_edge=1, only a 0-to-1 change of step_in is a step. With single_edge=0, every change of step_in is a step. The sampled level is the one held at the previous clock edge, and the position updates at the clock edge that sees the change.
- R5: An accepted step always goes to the next valid grid point of the current mode in the direction of travel. If the position is already on the grid, this is one full step. If it is off the grid after a mode change, it is the nearest grid point ahead.
- R6: The ratio code follows the fold k (0..16) of the position within its quadrant: k=0..2 gives 15, and k=3..15 give 14,13,12,11,10,9,8,7,6,5,4,3,2 in turn. k=16 gives 0. Codes stand for 15=100, 14=97, 13=92, 12=88, 11=83, 10=77, 9=71, 8=66, 7=55, 6=48, 5=40, 4=31, 3=20, 2=14 and 0=0 percent. Winding A uses k = low 4 bits when the quadrant (position bits 5:4) is even and 16 minus them when it is odd. Winding B uses the opposite fold.
- R7: Winding A drives forward in quadrants 0 and 3 and reverse in quadrants 1 and 2. Winding B drives forward in quadrants 0 and 1 and reverse in quadrants 2 and 3. A winding whose code is 0 has both drives off, and a winding's forward and reverse drives are never on together.
- R8: While enable is low, all four drives are off and both level codes read 0. Steps are not taken, and the position is held. step_in is still sampled, so a step_in change made during the disabled time produces no step after enable returns.
- R9: at_origin is 1 exactly when the position equals 8, whatever enable is.
- R10: In the full-step mode (single_edge=1, mode_sel=0), every accepted step ends on a position whose value modulo 16 is 8, so both windings carry 71%.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset to the home point |
| enable | input | 1 | High to run; low holds the angle and turns drives off |
| step_in | input | 1 | Synchronised step level |
| dir_ccw | input | 1 | 0 = position counts up, 1 = counts down |
| single_edge | input | 1 | 1 = rising edges only and coarse ladder; 0 = both edges and fine ladder |
| mode_sel | input | 2 | Excitation mode code |
| a_fwd | output | 1 | Winding A forward drive |
| a_rev | output | 1 | Winding A reverse drive |
| b_fwd | output | 1 | Winding B forward drive |
| b_rev | output | 1 | Winding B reverse drive |
| a_level | output | 4 | Winding A current-ratio code |
| b_level | output | 4 | Winding B current-ratio code |
| at_origin | output | 1 | Position is the home point |

## Verification
The hardest state to reach is a position that is off the grid for the current mode. It arises only after stepping in a fine mode and then switching to a coarser one, and the result of the rounding also depends on the direction. Directed cases step the fine mode to an odd position and then take one full-step move in each direction. Random runs change mode, direction and edge rule in the middle of motion, so off-grid rounding happens across many start points. Every output is compared each cycle with a model that finds the next grid point by walking one position at a time.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

    localparam int POS_W   = 6;
    localparam int AMP_W   = 4;
    localparam int QTR_W   = POS_W - 2;
    localparam int QTR_N   = 1 << QTR_W;
    localparam int KW      = QTR_W + 1;
    localparam int SHIFT_W = $clog2(QTR_W + 1);

    typedef logic [POS_W-1:0]   pos_t;
    typedef logic [AMP_W-1:0]   amp_t;
    typedef logic [SHIFT_W-1:0] shift_t;

    localparam pos_t HOME_POS = pos_t'(QTR_N / 2);

    typedef struct packed {
        pos_t pos;
        logic step_lvl;
    } seq_state_t;

    typedef struct packed {
        logic fwd;
        logic rev;
        amp_t level;
    } winding_t;

    // log2 of the step size for a mode selection
    function automatic shift_t mode_shift(input logic single_edge, input logic [1:0] mode_sel);
        if (single_edge)
            return shift_t'(QTR_W) - shift_t'(mode_sel);
        else
            return shift_t'(QTR_W - 1) - shift_t'(mode_sel);
    endfunction

    // current-ratio code for a fold index within a quarter turn
    function automatic amp_t quarter_level(input logic [KW-1:0] k);
        int n;
        case (int'(k))
            0, 1, 2: n = 15;
            3:       n = 14;
            4:       n = 13;
            5:       n = 12;
            6:       n = 11;
            7:       n = 10;
            8:       n = 9;
            9:       n = 8;
            10:      n = 7;
            11:      n = 6;
            12:      n = 5;
            13:      n = 4;
            14:      n = 3;
            15:      n = 2;
            default: n = 0;
        endcase
        return amp_t'(n);
    endfunction

endpackage

// File: rtl/ustep_edge_detect.sv
module ustep_edge_detect (
    input  logic lvl_now,
    input  logic lvl_prev,
    input  logic both_edges,
    output logic evt
);
    always_comb begin
        if (both_edges)
            evt = lvl_now ^ lvl_prev;
        else
            evt = lvl_now & ~lvl_prev;
    end
endmodule

// File: rtl/ustep_pos_next.sv
module ustep_pos_next
    import ustep_pkg::*;
(
    input  pos_t   pos_cur,
    input  logic   dir_down,
    input  shift_t step_shift,
    input  logic   odd_grid,
    output pos_t   pos_nxt
);
    pos_t step_sz;
    pos_t step_mask;
    pos_t grid_off;
    pos_t rel;
    pos_t up_pt;
    pos_t dn_pt;

    always_comb begin
        step_sz   = pos_t'(1) << step_shift;
        step_mask = step_sz - pos_t'(1);
        grid_off  = odd_grid ? HOME_POS : '0;
        rel       = pos_cur - grid_off;
        // round to the next grid point ahead, a full step when already aligned
        up_pt     = (rel | step_mask) + pos_t'(1);
        dn_pt     = (rel - pos_t'(1)) & ~step_mask;
        pos_nxt   = (dir_down ? dn_pt : up_pt) + grid_off;
    end
endmodule

// File: rtl/ustep_phase_decode.sv
module ustep_phase_decode
    import ustep_pkg::*;
#(
    parameter int WINDING = 0
) (
    input  pos_t     pos,
    input  logic     enable,
    output winding_t drive
);
    logic [1:0]       quad;
    logic [QTR_W-1:0] idx;
    logic [KW-1:0]    k;
    logic             positive;
    amp_t             lvl;

    always_comb begin
        quad = pos[POS_W-1 -: 2];
        idx  = pos[QTR_W-1:0];
        if (quad[0] ^ (WINDING != 0))
            k = KW'(QTR_N) - KW'(idx);
        else
            k = KW'(idx);
        if (WINDING == 0)
            positive = ~(quad[1] ^ quad[0]);
        else
            positive = ~quad[1];
        lvl = quarter_level(k);

        drive = '0;
        if (enable) begin
            drive.level = lvl;
            drive.fwd   = (lvl != '0) &&  positive;
            drive.rev   = (lvl != '0) && !positive;
        end
    end
endmodule

// File: rtl/ustep_sequencer.sv
module ustep_sequencer
    import ustep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             step_in,
    input  logic             dir_ccw,
    input  logic             single_edge,
    input  logic [1:0]       mode_sel,
    output logic             a_fwd,
    output logic             a_rev,
    output logic             b_fwd,
    output logic             b_rev,
    output logic [AMP_W-1:0] a_level,
    output logic [AMP_W-1:0] b_level,
    output logic             at_origin
);
    localparam int N_WIND = 2;

    seq_state_t st_d, st_q;
    logic       step_evt;
    pos_t       pos_nxt;
    shift_t     step_shift;
    logic       odd_grid;
    winding_t   wind [N_WIND];

    always_comb begin
        step_shift = mode_shift(single_edge, mode_sel);
        odd_grid   = single_edge && (mode_sel == 2'b00);
    end

    ustep_edge_detect u_edge (
        .lvl_now    (step_in),
        .lvl_prev   (st_q.step_lvl),
        .both_edges (~single_edge),
        .evt        (step_evt)
    );

    ustep_pos_next u_next (
        .pos_cur    (st_q.pos),
        .dir_down   (dir_ccw),
        .step_shift (step_shift),
        .odd_grid   (odd_grid),
        .pos_nxt    (pos_nxt)
    );

    always_comb begin
        st_d          = st_q;
        st_d.step_lvl = step_in;
        if (enable && step_evt)
            st_d.pos = pos_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos      <= HOME_POS;
            st_q.step_lvl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar w = 0; w < N_WIND; w++) begin : g_wind
        ustep_phase_decode #(.WINDING(w)) u_dec (
            .pos    (st_q.pos),
            .enable (enable),
            .drive  (wind[w])
        );
    end

    always_comb begin
        a_fwd     = wind[0].fwd;
        a_rev     = wind[0].rev;
        a_level   = wind[0].level;
        b_fwd     = wind[1].fwd;
        b_rev     = wind[1].rev;
        b_level   = wind[1].level;
        at_origin = (st_q.pos == HOME_POS);
    end
endmodule

// File: rtl/ustep_sequencer_chk.sv
module ustep_sequencer_chk
    import ustep_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             single_edge,
    input logic [1:0]       mode_sel,
    input logic             a_fwd,
    input logic             a_rev,
    input logic             b_fwd,
    input logic             b_rev,
    input logic [AMP_W-1:0] a_level,
    input logic [AMP_W-1:0] b_level,
    input logic             at_origin,
    input pos_t             pos_q
);
    assert_drive_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!a_fwd && !a_rev && !b_fwd && !b_rev && a_level == '0 && b_level == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(pos_q));

    assert_origin_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && at_origin) |-> (a_level == AMP_W'(9) && b_level == AMP_W'(9)));

    assert_no_shoot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_fwd && a_rev) && !(b_fwd && b_rev));

    assert_full_step_grid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pos_q) && $past(single_edge && mode_sel == 2'b00)) |-> (pos_q[QTR_W-1:0] == HOME_POS[QTR_W-1:0]));

    assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pos_t'(pos_q - $past(pos_q)) <= pos_t'(QTR_N)) ||
                  (pos_t'(pos_q - $past(pos_q)) >= pos_t'(3 * QTR_N))));

    assert_strong_winding_R6: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (a_level >= AMP_W'(9) || b_level >= AMP_W'(9)));
endmodule

bind ustep_sequencer ustep_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .single_edge (single_edge),
    .mode_sel    (mode_sel),
    .a_fwd       (a_fwd),
    .a_rev       (a_rev),
    .b_fwd       (b_fwd),
    .b_rev       (b_rev),
    .a_level     (a_level),
    .b_level     (b_level),
    .at_origin   (at_origin),
    .pos_q       (st_q.pos)
);

// File: tb/sim_ustep_sequencer.sv
module sim_ustep_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       step_in = 1'b0;
    logic       dir_ccw = 1'b0;
    logic       single_edge = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       a_fwd, a_rev, b_fwd, b_rev, at_origin;
    logic [3:0] a_level, b_level;

    int checks = 0;
    int errors = 0;
    int mpos = 8;
    bit mprev = 1'b0;

    always #4 clk = ~clk;

    ustep_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .step_in(step_in),
        .dir_ccw(dir_ccw), .single_edge(single_edge), .mode_sel(mode_sel),
        .a_fwd(a_fwd), .a_rev(a_rev), .b_fwd(b_fwd), .b_rev(b_rev),
        .a_level(a_level), .b_level(b_level), .at_origin(at_origin)
    );

    // R6 level ladder
    function automatic int exp_lvl(input int k);
        case (k)
            0, 1, 2: return 15;
            3:  return 14;  4:  return 13;  5:  return 12;  6:  return 11;
            7:  return 10;  8:  return 9;   9:  return 8;   10: return 7;
            11: return 6;   12: return 5;   13: return 4;   14: return 3;
            15: return 2;
            default: return 0;
        endcase
    endfunction

    // R6, R7, R8 expected drives and levels
    function automatic logic [11:0] exp_out(input int p, input bit en);
        int q = p / 16;
        int i = p % 16;
        int la = exp_lvl((q % 2 == 0) ? i : 16 - i);
        int lb = exp_lvl((q % 2 == 0) ? 16 - i : i);
        bit ap = (q == 0 || q == 3);
        bit bp = (q < 2);
        if (!en) return 12'd0;
        return {la != 0 && ap, la != 0 && !ap, lb != 0 && bp, lb != 0 && !bp, 4'(la), 4'(lb)};
    endfunction

    // R2, R5, R10: walk one position at a time to the next grid point
    function automatic int model_next(input int p, input bit ccw, input bit se, input int ms);
        int size = se ? (16 >> ms) : (8 >> ms);
        bit odd = se && (ms == 0);
        int x = p;
        bit ok;
        do begin
            x = ccw ? (x + 63) % 64 : (x + 1) % 64;
            ok = odd ? (x % 16 == 8) : (x % size == 0);
        end while (!ok);
        return x;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (model pos %0d)", tag, act, exp, mpos);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, {4'd0, a_fwd, a_rev, b_fwd, b_rev, a_level, b_level},
              {4'd0, exp_out(mpos, enable)});
        check("R9", {15'd0, at_origin}, {15'd0, mpos == 8});
    endtask

    // called at a negedge: drive, let one posedge pass, compare at next negedge
    task automatic apply(input bit st, input bit ccw, input bit se, input int ms,
                         input bit en, input string tag);
        bit edge_seen;
        step_in = st; dir_ccw = ccw; single_edge = se; mode_sel = 2'(ms); enable = en;
        @(posedge clk);
        if (en) begin
            edge_seen = se ? (st && !mprev) : (st != mprev);
            if (edge_seen) mpos = model_next(mpos, ccw, se, ms);
        end
        mprev = st;
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step_in = 1'b0; enable = 1'b1;
        repeat (3) @(negedge clk);
        mpos = 8; mprev = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit lvl;
        bit ccw;
        bit se;
        int ms;
        bit en;
        void'($urandom(32'd2024));
        @(negedge clk);
        // R1: state during reset and after release
        single_edge = 1'b1; mode_sel = 2'b01;
        @(negedge clk);
        compare_all("R1");
        do_reset();

        // R4: rising only counts with single_edge=1 (step size 8)
        apply(1, 0, 1, 1, 1, "R4");
        apply(0, 0, 1, 1, 1, "R4");
        apply(0, 0, 1, 1, 1, "R4");
        // R4: both edges count with single_edge=0
        apply(1, 0, 0, 1, 1, "R4");
        apply(0, 0, 0, 1, 1, "R4");
        // R3: reverse direction
        apply(1, 1, 0, 1, 1, "R3");
        apply(0, 1, 0, 1, 1, "R3");
        apply(1, 1, 0, 1, 1, "R3");

        // R2: one step in every mode code
        do_reset();
        lvl = 1'b0;
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 4; m++) begin
                lvl = ~lvl;
                if (s == 1 && lvl == 1'b0) apply(0, 0, 1, m, 1, "R2");
                apply(lvl, 0, s[0], m, 1, "R2");
                if (s == 1 && lvl == 1'b1) begin
                    lvl = 1'b0;
                    apply(0, 0, 1, m, 1, "R2");
                end
            end
        end

        // R5: fine steps to an off-grid point, then one full step each way
        do_reset();
        apply(1, 0, 0, 3, 1, "R5");
        apply(0, 0, 0, 3, 1, "R5");
        apply(1, 0, 0, 3, 1, "R5");
        apply(1, 0, 1, 0, 1, "R5");
        apply(0, 0, 1, 0, 1, "R5");
        apply(1, 0, 1, 0, 1, "R5");
        do_reset();
        apply(1, 1, 0, 3, 1, "R5");
        apply(0, 1, 0, 3, 1, "R5");
        apply(0, 1, 1, 2, 1, "R5");
        apply(1, 1, 1, 2, 1, "R5");
        apply(0, 1, 1, 0, 1, "R5");
        apply(1, 1, 1, 0, 1, "R5");

        // R10: full-step moves around the turn
        for (int n = 0; n < 6; n++) begin
            apply(0, n[2], 1, 0, 1, "R10");
            apply(1, n[2], 1, 0, 1, "R10");
        end

        // R8: disabled hold, ignored steps, no late step after re-enable
        apply(0, 0, 0, 1, 1, "R8");
        apply(1, 0, 0, 1, 0, "R8");
        apply(0, 1, 0, 2, 0, "R8");
        apply(1, 0, 1, 0, 0, "R8");
        apply(1, 0, 0, 1, 1, "R8");
        apply(1, 0, 0, 1, 1, "R8");

        // R6 and R7: walk the whole turn in the finest mode
        do_reset();
        lvl = 1'b0;
        for (int n = 0; n < 64; n++) begin
            lvl = ~lvl;
            apply(lvl, 0, 0, 3, 1, n[0] ? "R7" : "R6");
        end
        for (int n = 0; n < 64; n++) begin
            lvl = ~lvl;
            apply(lvl, 1, 0, 3, 1, "R6");
        end

        // random mix
        lvl = step_in; ccw = 0; se = 1; ms = 0; en = 1;
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(1, 0) == 1) lvl = ~lvl;
            if ($urandom_range(7, 0) == 0) ccw = ~ccw;
            if ($urandom_range(11, 0) == 0) begin
                se = $urandom_range(1, 0);
                ms = $urandom_range(3, 0);
            end
            en = ($urandom_range(15, 0) != 0);
            if ($urandom_range(599, 0) == 0) begin
                do_reset();
                lvl = 1'b0;
            end else begin
                apply(lvl, ccw, se, ms, en, "R5");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule